// File: doc/BRIEF.md
# I/Q Sample Input Formatter

This block is the parallel input stage of a dual-channel sample datapath. It takes 12-bit sample words from one shared bus or from two separate buses. It latches them on whichever edge of an external data clock the configuration selects, and it hands aligned in-phase/quadrature pairs to the core logic together with a one-cycle valid strobe. The data clock is slow compared with the core clock. The block oversamples it in the core domain, runs it either through a two-stage synchronizer or past it, and finds the chosen edge by comparing the current level with the previous one. The bus value and the bus-mode setting travel through the same flops as the clock level, so the word that is taken is always the one that was on the bus when the edge arrived.

On the shared bus, words alternate: the first word after reset or after a change of bus mode is the in-phase word, and the next is the quadrature word. A pair goes out once the quadrature word arrives. On separate buses, each active edge yields one pair at once. When offset binary is selected, the block turns each word into two's complement by inverting its top bit. A separate configuration bit sets the direction of the data clock pin, and the block drives it out as a registered flag.

Top module: `iq_input_formatter`

## Requirements
- R1: While reset is asserted and after it is released, `iq_valid` is 0, `iq_i` and `iq_q` are 0 and `dclk_dir` is 0, until the first data clock edge is accepted.
- R2: With `cfg_fall_edge` = 0, a word is taken only on a low-to-high transition of `dclk`. Bus values present at high-to-low transitions are never emitted.
- R3: With `cfg_fall_edge` = 1, a word is taken only on a high-to-low transition of `dclk`. Bus values present at low-to-high transitions are never emitted.
- R4: With `cfg_dual_port` = 0, accepted words from `bus_a` alternate between in-phase and quadrature, starting with in-phase. One pair (`iq_i` = first word, `iq_q` = second word) is emitted per quadrature word.
- R5: With `cfg_dual_port` = 1, every accepted edge emits one pair with `iq_i` from `bus_a` and `iq_q` from `bus_b`.
- R6: With `cfg_offset_bin` = 1, bit 11 of each emitted word is the inverse of the bus bit and bits 10..0 are unchanged (0x800 becomes 0x000, 0x7FF becomes 0xFFF). With 0, words pass unchanged.
- R7: `iq_valid` rises at the second rising core clock edge after the data clock transition is presented when `cfg_sync_bypass` = 1, and at the third when it is 0.
- R8: A change of `cfg_dual_port` realigns pairing, so that on the shared bus the next accepted word is in-phase. A half-built pair from before the change is discarded. When the change coincides with an accepted edge, that word is treated under the new mode.
- R9: `dclk_dir` equals `cfg_dclk_out` as sampled at the previous rising core clock edge.
- R10: `iq_valid` is high for exactly one core cycle per pair, and `iq_i`/`iq_q` hold their values until the next pair.
- R11: With `cfg_dual_port` = 0, the value of `bus_b` has no effect on the emitted pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dclk | input | 1 | External data clock, oversampled by `clk` |
| bus_a | input | 12 | Shared bus, or in-phase bus in dual mode |
| bus_b | input | 12 | Quadrature bus in dual mode, unused otherwise |
| cfg_offset_bin | input | 1 | 1: input words are offset binary |
| cfg_dual_port | input | 1 | 1: separate buses, 0: interleaved shared bus |
| cfg_fall_edge | input | 1 | 1: latch on falling data clock edge |
| cfg_sync_bypass | input | 1 | 1: skip the two-stage synchronizer |
| cfg_dclk_out | input | 1 | Requested data clock pin direction (1 = output) |
| iq_i | output | 12 | In-phase word, two's complement |
| iq_q | output | 12 | Quadrature word, two's complement |
| iq_valid | output | 1 | One-cycle strobe for a new pair |
| dclk_dir | output | 1 | Registered data clock direction flag |

## Verification
The sharpest overlap is a bus-mode change that lands in the same core cycle as an accepted data clock edge. That cycle must both realign the pairing and decide which mode the new word belongs to. The bench switches from separate buses to the shared bus on the very sample where `dclk` makes its active transition, with a distinct value on `bus_b`. It judges the result by the absence of a pair on that edge and by the next word completing a pair whose in-phase half is the word taken in the switching cycle. A second run leaves half a pair pending, toggles the mode away and back, and confirms that the stale word never appears.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned IQF_WORD_W   = 12;
  localparam int unsigned IQF_SYNC_DEP = 2;

  typedef enum logic {
    PH_I = 1'b0,
    PH_Q = 1'b1
  } iqf_phase_e;
endpackage

// File: rtl/iqf_sampler.sv
module iqf_sampler
  import iqf_pkg::*;
#(
  parameter int unsigned DW          = IQF_WORD_W,
  parameter int unsigned SYNC_STAGES = IQF_SYNC_DEP
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          dclk_i,
  input  logic          dual_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          bypass_i,
  input  logic          fall_i,
  output logic          edge_o,
  output logic          dual_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned SW   = 2 * DW + 2;
  localparam int unsigned LAST = SYNC_STAGES - 1;

  // Each stage holds {clock level, bus mode, bus a, bus b}
  logic [SYNC_STAGES-1:0][SW-1:0] stg_q;
  logic [SW-1:0]                  sel;
  logic                           sel_ck;
  logic                           prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= {dclk_i, dual_i, a_i, b_i};
  end

  generate
    for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stg_q[k] <= '0;
        else         stg_q[k] <= stg_q[k-1];
      end
    end
  endgenerate

  always_comb begin
    sel    = bypass_i ? stg_q[0] : stg_q[LAST];
    sel_ck = sel[SW-1];
    dual_o = sel[SW-2];
    a_o    = sel[2*DW-1:DW];
    b_o    = sel[DW-1:0];
    edge_o = fall_i ? (prev_q & ~sel_ck) : (~prev_q & sel_ck);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel_ck;
  end

  // R2: an accepted edge cannot repeat in the following cycle
  p_edge_gap_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/iqf_demux.sv
module iqf_demux
  import iqf_pkg::*;
#(
  parameter int unsigned DW = IQF_WORD_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic          dual_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          offset_i,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o,
  output logic          vld_o
);
  timeunit 1ns;
  timeprecision 1ps;

  function automatic logic [DW-1:0] to_twos(input logic [DW-1:0] w, input logic ob);
    return ob ? {~w[DW-1], w[DW-2:0]} : w;
  endfunction

  iqf_phase_e    phase_q, phase_d, ph_eff;
  logic          dual_q;
  logic          realign;
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] i_q, q_q, i_d, q_d;
  logic          vld_q, vld_d;

  always_comb begin
    realign = (dual_i != dual_q);
    ph_eff  = realign ? PH_I : phase_q;
    phase_d = ph_eff;
    hold_d  = hold_q;
    i_d     = i_q;
    q_d     = q_q;
    vld_d   = 1'b0;
    if (edge_i) begin
      if (dual_i) begin
        i_d     = to_twos(a_i, offset_i);
        q_d     = to_twos(b_i, offset_i);
        vld_d   = 1'b1;
        phase_d = PH_I;
      end else if (ph_eff == PH_I) begin
        hold_d  = to_twos(a_i, offset_i);
        phase_d = PH_Q;
      end else begin
        i_d     = hold_q;
        q_d     = to_twos(a_i, offset_i);
        vld_d   = 1'b1;
        phase_d = PH_I;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_I;
      dual_q  <= 1'b0;
      hold_q  <= '0;
      i_q     <= '0;
      q_q     <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dual_q  <= dual_i;
      vld_q   <= vld_d;
      if (edge_i) hold_q <= hold_d;
      if (vld_d) begin
        i_q <= i_d;
        q_q <= q_d;
      end
    end
  end

  assign i_o   = i_q;
  assign q_o   = q_q;
  assign vld_o = vld_q;

  // R2: a pair only follows an accepted data clock edge
  p_vld_from_edge_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_o |-> $past(edge_i));
  // R10: the strobe lasts one cycle
  p_vld_single_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  // R5: an edge on separate buses yields a pair at once
  p_dual_pair_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (edge_i && dual_i) |=> vld_o);
  // R6: offset binary flips the top bit
  p_offset_msb_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (edge_i && dual_i && offset_i) |=> (i_o[DW-1] != $past(a_i[DW-1])));
  // R8: a mode change without an edge restarts at in-phase
  p_realign_idle_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (realign && !edge_i) |=> (phase_q == PH_I));
  // R8: a mode change on a shared-bus edge takes that word as in-phase
  p_realign_edge_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (realign && edge_i && !dual_i) |=> (phase_q == PH_Q && !vld_o));
endmodule

// File: rtl/iq_input_formatter.sv
module iq_input_formatter
  import iqf_pkg::*;
#(
  parameter int unsigned DATA_W      = IQF_WORD_W,
  parameter int unsigned SYNC_STAGES = IQF_SYNC_DEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic [DATA_W-1:0] bus_a,
  input  logic [DATA_W-1:0] bus_b,
  input  logic              cfg_offset_bin,
  input  logic              cfg_dual_port,
  input  logic              cfg_fall_edge,
  input  logic              cfg_sync_bypass,
  input  logic              cfg_dclk_out,
  output logic [DATA_W-1:0] iq_i,
  output logic [DATA_W-1:0] iq_q,
  output logic              iq_valid,
  output logic              dclk_dir
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic              smp_edge;
  logic              smp_dual;
  logic [DATA_W-1:0] smp_a, smp_b;
  logic              dir_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  iqf_sampler #(
    .DW          (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst_ni   (rst_s),
    .dclk_i   (dclk),
    .dual_i   (cfg_dual_port),
    .a_i      (bus_a),
    .b_i      (bus_b),
    .bypass_i (cfg_sync_bypass),
    .fall_i   (cfg_fall_edge),
    .edge_o   (smp_edge),
    .dual_o   (smp_dual),
    .a_o      (smp_a),
    .b_o      (smp_b)
  );

  iqf_demux #(
    .DW (DATA_W)
  ) u_demux (
    .clk      (clk),
    .rst_ni   (rst_s),
    .edge_i   (smp_edge),
    .dual_i   (smp_dual),
    .a_i      (smp_a),
    .b_i      (smp_b),
    .offset_i (cfg_offset_bin),
    .i_o      (iq_i),
    .q_o      (iq_q),
    .vld_o    (iq_valid)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) dir_q <= 1'b0;
    else        dir_q <= cfg_dclk_out;
  end
  assign dclk_dir = dir_q;

  // R9: direction flag follows its configuration bit by one cycle
  p_dir_follow_r9: assert property (@(posedge clk) disable iff (!rst_s)
    rst_s |=> (dclk_dir == $past(cfg_dclk_out)));
  // R1: nothing is emitted while the internal reset holds
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_s |-> !iq_valid);
endmodule

// File: tb/iq_input_formatter_test.sv
module iq_input_formatter_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dclk = 1'b0;
  logic [11:0] bus_a = '0;
  logic [11:0] bus_b = '0;
  logic        cfg_offset_bin = 1'b0;
  logic        cfg_dual_port = 1'b0;
  logic        cfg_fall_edge = 1'b0;
  logic        cfg_sync_bypass = 1'b0;
  logic        cfg_dclk_out = 1'b0;
  logic [11:0] iq_i, iq_q;
  logic        iq_valid, dclk_dir;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int act_cyc = 0;
  int cap_n = 0;
  logic [11:0] cap_i [0:63];
  logic [11:0] cap_q [0:63];
  int          cap_c [0:63];

  iq_input_formatter uut (
    .clk (clk), .rst_n (rst_n), .dclk (dclk), .bus_a (bus_a), .bus_b (bus_b),
    .cfg_offset_bin (cfg_offset_bin), .cfg_dual_port (cfg_dual_port),
    .cfg_fall_edge (cfg_fall_edge), .cfg_sync_bypass (cfg_sync_bypass),
    .cfg_dclk_out (cfg_dclk_out), .iq_i (iq_i), .iq_q (iq_q),
    .iq_valid (iq_valid), .dclk_dir (dclk_dir)
  );

  always #5ns clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (iq_valid && cap_n < 64) begin
      cap_i[cap_n] = iq_i;
      cap_q[cap_n] = iq_q;
      cap_c[cap_n] = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Inactive transition with filler data, then active transition with the word
  task automatic put_word(input logic [11:0] a, input logic [11:0] b);
    dclk  = cfg_fall_edge;
    bus_a = 12'hE5E;
    bus_b = 12'h1C3;
    idle(4);
    dclk    = ~cfg_fall_edge;
    bus_a   = a;
    bus_b   = b;
    act_cyc = cyc;
    idle(4);
  endtask

  task automatic put_word_mode(input logic [11:0] a, input logic [11:0] b, input logic dual);
    dclk  = cfg_fall_edge;
    bus_a = 12'hE5E;
    bus_b = 12'h1C3;
    idle(4);
    dclk          = ~cfg_fall_edge;
    bus_a         = a;
    bus_b         = b;
    cfg_dual_port = dual;
    act_cyc       = cyc;
    idle(4);
  endtask

  task automatic t_reset;
    idle(3);
    chk("R1 valid in reset", int'(iq_valid), 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 valid", int'(iq_valid), 0);
    chk("R1 iq_i", int'(iq_i), 0);
    chk("R1 iq_q", int'(iq_q), 0);
    chk("R1 dclk_dir", int'(dclk_dir), 0);
  endtask

  task automatic t_dir;
    cfg_dclk_out = 1'b1;
    idle(1);
    chk("R9 dir set", int'(dclk_dir), 1);
    cfg_dclk_out = 1'b0;
    idle(1);
    chk("R9 dir clear", int'(dclk_dir), 0);
  endtask

  task automatic t_dual_rise;
    int base;
    cfg_dual_port = 1'b1;
    idle(4);
    base = cap_n;
    put_word(12'h123, 12'h456);
    put_word(12'hABC, 12'h0F0);
    chk("R2 R5 pair count", cap_n - base, 2);
    chk("R5 pair0 i", int'(cap_i[base]), 'h123);
    chk("R5 pair0 q", int'(cap_q[base]), 'h456);
    chk("R5 pair1 i", int'(cap_i[base+1]), 'hABC);
    chk("R5 pair1 q", int'(cap_q[base+1]), 'h0F0);
  endtask

  task automatic t_interleave;
    int base;
    cfg_dual_port = 1'b0;
    idle(4);
    base = cap_n;
    put_word(12'h111, 12'h5A5);
    put_word(12'h222, 12'h0F0);
    put_word(12'h333, 12'hFFF);
    put_word(12'h444, 12'h001);
    chk("R4 pair count", cap_n - base, 2);
    chk("R4 R11 pair0 i", int'(cap_i[base]), 'h111);
    chk("R4 R11 pair0 q", int'(cap_q[base]), 'h222);
    chk("R4 R11 pair1 i", int'(cap_i[base+1]), 'h333);
    chk("R4 R11 pair1 q", int'(cap_q[base+1]), 'h444);
  endtask

  task automatic t_fall;
    int base;
    cfg_dual_port = 1'b1;
    cfg_fall_edge = 1'b1;
    idle(4);
    base = cap_n;
    put_word(12'h3C3, 12'hC3C);
    chk("R3 pair count", cap_n - base, 1);
    chk("R3 i", int'(cap_i[base]), 'h3C3);
    chk("R3 q", int'(cap_q[base]), 'hC3C);
    cfg_fall_edge = 1'b0;
    idle(4);
  endtask

  task automatic t_offset;
    int base;
    cfg_dual_port  = 1'b1;
    cfg_offset_bin = 1'b1;
    idle(4);
    base = cap_n;
    put_word(12'h800, 12'h7FF);
    put_word(12'h123, 12'hFED);
    chk("R6 count", cap_n - base, 2);
    chk("R6 0x800", int'(cap_i[base]), 'h000);
    chk("R6 0x7FF", int'(cap_q[base]), 'hFFF);
    chk("R6 0x123", int'(cap_i[base+1]), 'h923);
    chk("R6 0xFED", int'(cap_q[base+1]), 'h7ED);
    cfg_offset_bin = 1'b0;
    idle(2);
  endtask

  task automatic t_latency;
    int base;
    cfg_dual_port   = 1'b1;
    cfg_sync_bypass = 1'b1;
    idle(4);
    base = cap_n;
    put_word(12'h0A1, 12'h0B2);
    chk("R7 bypass latency", cap_c[base] - act_cyc, 2);
    chk("R10 one strobe", cap_n - base, 1);
    chk("R10 valid low after", int'(iq_valid), 0);
    chk("R10 i held", int'(iq_i), 'h0A1);
    cfg_sync_bypass = 1'b0;
    idle(4);
    base = cap_n;
    put_word(12'h0C3, 12'h0D4);
    chk("R7 sync latency", cap_c[base] - act_cyc, 3);
    chk("R10 q held", int'(iq_q), 'h0D4);
  endtask

  task automatic t_realign;
    int base;
    // Pending half pair discarded by a mode round trip
    cfg_dual_port = 1'b0;
    idle(4);
    base = cap_n;
    put_word(12'h101, 12'h000);
    cfg_dual_port = 1'b1;
    idle(4);
    cfg_dual_port = 1'b0;
    idle(4);
    put_word(12'h202, 12'h000);
    put_word(12'h303, 12'h000);
    chk("R8 round trip count", cap_n - base, 1);
    chk("R8 round trip i", int'(cap_i[base]), 'h202);
    chk("R8 round trip q", int'(cap_q[base]), 'h303);
    // Mode change in the same cycle as an accepted edge
    cfg_dual_port = 1'b1;
    idle(4);
    base = cap_n;
    put_word_mode(12'h404, 12'h999, 1'b0);
    chk("R8 same-cycle no pair", cap_n - base, 0);
    put_word(12'h505, 12'h888);
    chk("R8 same-cycle count", cap_n - base, 1);
    chk("R8 same-cycle i", int'(cap_i[base]), 'h404);
    chk("R8 same-cycle q", int'(cap_q[base]), 'h505);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_dir();
    t_dual_rise();
    t_interleave();
    t_fall();
    t_offset();
    t_latency();
    t_realign();
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule